// File: doc/BRIEF.md
# Short Branch and Predicate-Flag Unit

This unit executes the conditional-transfer group of the 16-bit compact instruction format. Each cycle it may accept one decoded parcel. The parcel carries a 4-bit condition selector and an 8-bit operand. The unit also takes the parcel's address and three condition-code bits: zero, overflow and carry. None of the conditions tested by this group depends on the sign bit, so the sign bit is not an input.

For a parcel accepted in cycle t, the results appear after the clock edge that ends cycle t:
- a branch decision, with a target address;
- an update to a single predicate flag;
- a supervisor-call request carrying the operand as its service number;
- an illegal-instruction indication.

The unit only raises these signals. Fetch redirection, pipeline flushing and trap entry belong to the surrounding pipeline. The unit never writes the condition codes.

Four selector values that have no branch meaning are reused:
- three of them write the predicate flag;
- one requests a supervisor call.

One further unused value, 9, is reported as illegal.

Top module: `brpred_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first accepted parcel: branchTaken, svcReq and illegalOp are 0, and predFlag is 0.
- R2: For a valid parcel with selector 1..8, 10 or 11, branchTaken is 1 in the following cycle exactly when the condition holds. The conditions are:
  - 1: C
  - 2: Z
  - 3: C or Z
  - 4: not C and not Z
  - 5: not Z
  - 6: not C
  - 7: not V
  - 8: V
  - 10: C
  - 11: not C
- R3: A valid parcel with selector 15 is always taken, whatever the condition codes.
- R4: When branchTaken is 1, branchTarget equals the parcel address plus 2 plus twice the sign-extended 8-bit operand, modulo 2^ADDR_W. An operand of 0 therefore targets the next parcel, and the reach is -128 to +127 parcels. Header slots get no special treatment.
- R5: Selector 0 writes predFlag with the truth of the condition named by operand bits [3:0]. That condition uses the table of R2 and R3. Operand nibbles 0, 9, 12, 13 and 14 name no condition and count as false.
- R6: Selector 12 sets predFlag to 1 when the operand-nibble condition holds, and otherwise leaves it unchanged.
- R7: Selector 13 clears predFlag to 0 when the operand-nibble condition holds, and otherwise leaves it unchanged.
- R8: Selector 14 raises svcReq for one cycle, with svcCode equal to the full 8-bit operand. It is never taken.
- R9: Selector 9 raises illegalOp for one cycle. No branch is taken, no supervisor call is raised and predFlag does not change.
- R10: A cycle with instValid low produces no taken branch, no supervisor call and no illegal indication, and leaves predFlag unchanged.
- R11: In any cycle, at most one of branchTaken, svcReq and illegalOp is 1. The flag-writing selectors 0, 12 and 13 never raise any of the three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A parcel of this group is presented this cycle |
| condField | input | 4 | Condition selector |
| operand | input | OPND_W | Displacement, flag-condition nibble or service number |
| instAddr | input | ADDR_W | Byte address of the parcel |
| ccZ | input | 1 | Zero condition code |
| ccV | input | 1 | Overflow condition code |
| ccC | input | 1 | Carry condition code |
| branchTaken | output | 1 | Branch decision, one cycle after the parcel |
| branchTarget | output | ADDR_W | Target address, meaningful when branchTaken is 1 |
| predFlag | output | 1 | Predicate flag |
| svcReq | output | 1 | Supervisor-call request pulse |
| svcCode | output | OPND_W | Service number of the latest supervisor call |
| illegalOp | output | 1 | Illegal-selector pulse |

## Verification
The bench builds the unit with ADDR_W = 16 and the default 8-bit operand.

With a 16-bit address, random parcel addresses land close to the top of the space often enough that the modulo wraparound of R4 is exercised. A directed parcel at 0xFFFE with displacement 0, whose target is 0x0000, covers it explicitly. The directed parcels also cover the most negative displacement (-128) and the most positive one (+127).

The random stream mixes every selector value with random condition codes. This mix exercises unused operand nibbles under the flag-writing selectors.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

  // Selector values whose meaning is not a branch condition
  localparam logic [3:0] SEL_TO_FLAG  = 4'd0;
  localparam logic [3:0] SEL_ILLEGAL  = 4'd9;
  localparam logic [3:0] SEL_SET_FLAG = 4'd12;
  localparam logic [3:0] SEL_CLR_FLAG = 4'd13;
  localparam logic [3:0] SEL_SVC      = 4'd14;

  typedef struct packed {
    logic takeBr;
    logic flagWr;
    logic flagVal;
    logic svc;
    logic illegal;
  } ctrlStrb_t;

  // Truth of a branch condition; selectors without a condition yield 0
  function automatic logic evalCond(input logic [3:0] sel, input logic z,
                                    input logic v, input logic c);
    logic r;
    case (sel)
      4'd1:    r = c;
      4'd2:    r = z;
      4'd3:    r = c | z;
      4'd4:    r = ~c & ~z;
      4'd5:    r = ~z;
      4'd6:    r = ~c;
      4'd7:    r = ~v;
      4'd8:    r = v;
      4'd10:   r = c;
      4'd11:   r = ~c;
      4'd15:   r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/brpred_ctrl.sv
module brpred_ctrl
  import brpred_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      instValid,
  input  logic [3:0] condField,
  input  logic [3:0] selNibble,
  input  logic      ccZ,
  input  logic      ccV,
  input  logic      ccC,
  output ctrlStrb_t strb
);

  logic brHolds;
  logic nibHolds;

  always_comb begin
    brHolds  = evalCond(condField, ccZ, ccV, ccC);
    nibHolds = evalCond(selNibble, ccZ, ccV, ccC);
    strb     = '0;
    if (instValid) begin
      case (condField)
        SEL_TO_FLAG: begin
          strb.flagWr  = 1'b1;
          strb.flagVal = nibHolds;
        end
        SEL_SET_FLAG: begin
          strb.flagWr  = nibHolds;
          strb.flagVal = 1'b1;
        end
        SEL_CLR_FLAG: begin
          strb.flagWr  = nibHolds;
          strb.flagVal = 1'b0;
        end
        SEL_SVC:     strb.svc     = 1'b1;
        SEL_ILLEGAL: strb.illegal = 1'b1;
        default:     strb.takeBr  = brHolds;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.takeBr, strb.flagWr, strb.svc, strb.illegal})); // R11

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && condField == 4'd15) |-> strb.takeBr); // R3

  AST_SEL9_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && condField == 4'd9) |-> (strb.illegal && !strb.flagWr)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |-> (strb == '0)); // R10

endmodule

// File: rtl/brpred_dpath.sv
module brpred_dpath
  import brpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [OPND_W-1:0] operand,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              predFlag,
  output logic              svcReq,
  output logic [OPND_W-1:0] svcCode,
  output logic              illegalOp
);

  localparam int EXT_W = ADDR_W - OPND_W;
  localparam logic [ADDR_W-1:0] PARCEL_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] nextTgt;

  always_comb begin
    dispExt = {{EXT_W{operand[OPND_W-1]}}, operand};
    nextTgt = instAddr + PARCEL_BYTES + (dispExt << 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      predFlag     <= 1'b0;
      svcReq       <= 1'b0;
      svcCode      <= '0;
      illegalOp    <= 1'b0;
    end else begin
      branchTaken <= strb.takeBr;
      svcReq      <= strb.svc;
      illegalOp   <= strb.illegal;
      if (strb.takeBr) branchTarget <= nextTgt;
      if (strb.flagWr) predFlag     <= strb.flagVal;
      if (strb.svc)    svcCode      <= operand;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.flagWr) |-> $stable(predFlag)); // R10

  AST_SVC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    svcReq |-> (!branchTaken && !illegalOp)); // R11

  AST_SVC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.svc |=> (svcReq && svcCode == $past(operand))); // R8

endmodule

// File: rtl/brpred_unit.sv
module brpred_unit
  import brpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [3:0]        condField,
  input  logic [OPND_W-1:0] operand,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              ccZ,
  input  logic              ccV,
  input  logic              ccC,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              predFlag,
  output logic              svcReq,
  output logic [OPND_W-1:0] svcCode,
  output logic              illegalOp
);

  ctrlStrb_t strb;

  brpred_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .instValid (instValid),
    .condField (condField),
    .selNibble (operand[3:0]),
    .ccZ       (ccZ),
    .ccV       (ccV),
    .ccC       (ccC),
    .strb      (strb)
  );

  brpred_dpath #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .instAddr     (instAddr),
    .operand      (operand),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .predFlag     (predFlag),
    .svcReq       (svcReq),
    .svcCode      (svcCode),
    .illegalOp    (illegalOp)
  );

endmodule

// File: tb/brpred_unit_tb.sv
module brpred_unit_tb;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instValid = 1'b0;
  logic [3:0]    condField = '0;
  logic [7:0]    operand = '0;
  logic [AW-1:0] instAddr = '0;
  logic          ccZ = 1'b0, ccV = 1'b0, ccC = 1'b0;
  logic          branchTaken, predFlag, svcReq, illegalOp;
  logic [AW-1:0] branchTarget;
  logic [7:0]    svcCode;

  int checks = 0;
  int errors = 0;

  logic expFlag = 1'b0;
  logic [7:0] expCode = '0;

  always #5 clk = ~clk;

  brpred_unit #(.ADDR_W(AW), .OPND_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .condField(condField),
    .operand(operand), .instAddr(instAddr), .ccZ(ccZ), .ccV(ccV), .ccC(ccC),
    .branchTaken(branchTaken), .branchTarget(branchTarget), .predFlag(predFlag),
    .svcReq(svcReq), .svcCode(svcCode), .illegalOp(illegalOp)
  );

  function automatic logic condTrue(input logic [3:0] s, input logic z, v, c);
    if (s == 4'd15) return 1'b1;
    if (s == 4'd1 || s == 4'd10) return c;
    if (s == 4'd11 || s == 4'd6) return !c;
    if (s == 4'd2) return z;
    if (s == 4'd5) return !z;
    if (s == 4'd3) return c || z;
    if (s == 4'd4) return !c && !z;
    if (s == 4'd7) return !v;
    if (s == 4'd8) return v;
    return 1'b0;
  endfunction

  function automatic logic [AW-1:0] tgtOf(input logic [AW-1:0] a, input logic [7:0] d);
    int signed off;
    off = $signed(d);
    return AW'(int'(a) + 2 + 2 * off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, check results after the posedge
  task automatic step(input logic v, input logic [3:0] s, input logic [7:0] op,
                      input logic [AW-1:0] a, input logic z, input logic ov, input logic c);
    logic eTaken, eSvc, eIll, nib;
    string rq;
    instValid = v; condField = s; operand = op; instAddr = a;
    ccZ = z; ccV = ov; ccC = c;
    eTaken = 1'b0; eSvc = 1'b0; eIll = 1'b0;
    nib = condTrue(op[3:0], z, ov, c);
    rq = "R10";
    if (v) begin
      case (s)
        4'd0:  begin expFlag = nib; rq = "R5"; end
        4'd12: begin if (nib) expFlag = 1'b1; rq = "R6"; end
        4'd13: begin if (nib) expFlag = 1'b0; rq = "R7"; end
        4'd14: begin eSvc = 1'b1; expCode = op; rq = "R8"; end
        4'd9:  begin eIll = 1'b1; rq = "R9"; end
        4'd15: begin eTaken = 1'b1; rq = "R3"; end
        default: begin eTaken = condTrue(s, z, ov, c); rq = "R2"; end
      endcase
    end
    @(posedge clk);
    #2;
    chk(rq, 32'(branchTaken), 32'(eTaken));
    if (eTaken) chk("R4", 32'(branchTarget), 32'(tgtOf(a, op)));
    chk(rq, 32'(predFlag), 32'(expFlag));
    chk(rq, 32'(svcReq), 32'(eSvc));
    if (eSvc) chk("R8", 32'(svcCode), 32'(expCode));
    chk(rq, 32'(illegalOp), 32'(eIll));
    chk("R11", 32'(branchTaken) + 32'(svcReq) + 32'(illegalOp) <= 1 ? 32'd1 : 32'd0, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state, with stimulus that would otherwise act
    instValid = 1'b1; condField = 4'd15; operand = 8'h0F;
    repeat (3) @(negedge clk);
    chk("R1", 32'(branchTaken), 0);
    chk("R1", 32'(svcReq), 0);
    chk("R1", 32'(illegalOp), 0);
    chk("R1", 32'(predFlag), 0);
    instValid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(predFlag), 0);

    // Directed corners
    step(1, 4'd15, 8'h00, 16'h1000, 1, 1, 1);   // R4 disp 0
    step(1, 4'd15, 8'h80, 16'h1000, 0, 0, 0);   // R4 disp -128
    step(1, 4'd15, 8'h7F, 16'h1000, 0, 0, 0);   // R4 disp +127
    step(1, 4'd15, 8'h00, 16'hFFFE, 0, 0, 0);   // R4 wraparound
    step(1, 4'd0,  8'h0F, 16'h0000, 0, 0, 0);   // R5 flag := 1
    step(1, 4'd9,  8'h00, 16'h0000, 0, 0, 0);   // R9 flag held
    step(1, 4'd13, 8'h09, 16'h0000, 0, 0, 0);   // R7 nibble 9 false -> held
    step(1, 4'd13, 8'h02, 16'h0000, 1, 0, 0);   // R7 clear
    step(1, 4'd12, 8'h0E, 16'h0000, 1, 1, 1);   // R6 nibble 14 false -> held
    step(1, 4'd12, 8'h08, 16'h0000, 0, 1, 0);   // R6 set
    step(0, 4'd13, 8'h0F, 16'h0000, 0, 0, 0);   // R10 invalid, flag held
    step(0, 4'd15, 8'h00, 16'h0000, 0, 0, 0);   // R10 not taken
    step(1, 4'd14, 8'hA5, 16'h0000, 0, 0, 0);   // R8
    step(1, 4'd4,  8'h10, 16'h2000, 0, 0, 0);   // R2 high
    step(1, 4'd4,  8'h10, 16'h2000, 1, 0, 0);   // R2 high false

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[2:0] != 3'd0), r[6:3], r[14:7], AW'($urandom), r[15], r[16], r[17]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule